// File: doc/BRIEF.md
# Page Programming Sequencer for a Byte-Wide Flash

This block is the host-side controller that writes one page into an external byte-wide flash device whose writes are guarded by a three-byte unlock. A start request carries a page number and a byte count. The sequencer then drives a simple synchronous memory bus through the whole program operation:

- It issues the unlock writes.
- It streams the requested bytes from a local page buffer in ascending byte order, one write per cycle.
- It stays silent on the bus long enough for the device's load window to close, so that the device begins its internal programming.
- It polls the device with reads until bit 6 stops toggling between consecutive reads.

Completion is reported with a one-cycle done pulse. If bit 6 is still toggling when a cycle limit set by a parameter runs out, the sequencer reports a one-cycle timeout pulse instead. The limit should be set above the device's worst-case programming time of 10 ms.

Top module: `page_prog_seq`

## Requirements
- R1: After reset, busy_o, done_o, timeout_o, mem_we_o and mem_re_o are all low.
- R2: When start_i is sampled high while idle, the next three cycles carry write strobes with address/data 5555h/AAh, then 2AAAh/55h, then 5555h/A0h, in that order.
- R3: Directly after the unlock, with no idle cycle, the block makes count_m1_i+1 writes on consecutive cycles. Write k has address {page_i, k}, where page_i forms address bits 16..7 and k forms bits 6..0, k running upward from 0. Its data is buf_data_i sampled while buf_addr_o equals k.
- R4: After the last data write, neither strobe is raised for at least QUIET_CYC cycles before the first poll read.
- R5: Every poll read targets the address of the last byte written. Reads are issued every second cycle, and mem_rdata_i is taken one cycle after the read strobe.
- R6: When two consecutive poll reads agree in bit 6, done_o pulses for exactly one cycle and no further reads follow. If bit 6 flips F times, this takes exactly F+2 reads.
- R7: If bit 6 is still toggling after about POLL_LIMIT cycles of polling, timeout_o pulses for one cycle, done_o stays low, and polling stops.
- R8: A start_i pulse while busy is ignored: the running operation keeps its page and count, and only one completion pulse follows.
- R9: mem_we_o and mem_re_o are never high together, and neither is high while busy_o is low.
- R10: busy_o rises the cycle after start_i is accepted and falls in the cycle after the done or timeout pulse. done_o and timeout_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| page_i | input | 10 | Page number (address bits 16..7) |
| count_m1_i | input | 7 | Number of bytes minus one (0..127) |
| buf_addr_o | output | 7 | Page buffer read offset |
| buf_data_i | input | 8 | Page buffer data for buf_addr_o, same cycle |
| mem_addr_o | output | 17 | Device bus address |
| mem_wdata_o | output | 8 | Device bus write data |
| mem_we_o | output | 1 | Write strobe, one write per high cycle |
| mem_re_o | output | 1 | Read strobe, one read per high cycle |
| mem_rdata_i | input | 8 | Read data, valid the cycle after mem_re_o |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| timeout_o | output | 1 | One-cycle pulse when polling gives up |

## Verification
Some properties are checked by assertions on every cycle:
- The two strobes never overlap, and the bus stays quiet while idle.
- Done and timeout are single-cycle and mutually exclusive, and busy falls right after either one.
- The latched page cannot change during an operation.

Other behaviour can only be shown by the bench's scenarios, which log every bus transaction and compare it with expected values:
- the exact unlock order;
- the ascending data stream and where its data comes from;
- the length of the quiet gap;
- the number of poll reads against a device model with a chosen flip count;
- the timeout path.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_UNLK  = 3'd1,
    S_LOAD  = 3'd2,
    S_QUIET = 3'd3,
    S_PRD   = 3'd4,
    S_PCHK  = 3'd5,
    S_FOK   = 3'd6,
    S_FTO   = 3'd7
  } pps_state_t;

  localparam int UNLOCK_LEN = 3;

  function automatic logic [14:0] unlock_addr(input logic [1:0] k);
    return (k == 2'd1) ? 15'h2AAA : 15'h5555;
  endfunction

  function automatic logic [7:0] unlock_data(input logic [1:0] k);
    case (k)
      2'd0:    return 8'hAA;
      2'd1:    return 8'h55;
      default: return 8'hA0;
    endcase
  endfunction

endpackage

// File: rtl/pps_down_timer.sv
module pps_down_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (dec && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pps_toggle_cmp.sv
module pps_toggle_cmp (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sample,
  input  logic bit_i,
  output logic settled
);
  logic prev_q, have_q;
  logic prev_d, have_d;

  always_comb begin
    prev_d = prev_q;
    have_d = have_q;
    if (clr) begin
      have_d = 1'b0;
    end else if (sample) begin
      prev_d = bit_i;
      have_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      have_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      have_q <= have_d;
    end
  end

  assign settled = have_q && (prev_q == bit_i);
endmodule

// File: rtl/pps_bus_mux.sv
module pps_bus_mux
  import pps_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int OFS_W  = 7
) (
  input  pps_state_t              st,
  input  logic [OFS_W-1:0]        idx,
  input  logic [ADDR_W-OFS_W-1:0] page,
  input  logic [OFS_W-1:0]        last,
  input  logic [DATA_W-1:0]       buf_data,
  output logic [ADDR_W-1:0]       addr,
  output logic [DATA_W-1:0]       wdata
);
  always_comb begin
    addr  = '0;
    wdata = '0;
    case (st)
      S_UNLK: begin
        addr  = ADDR_W'(unlock_addr(idx[1:0]));
        wdata = DATA_W'(unlock_data(idx[1:0]));
      end
      S_LOAD: begin
        addr  = {page, idx};
        wdata = buf_data;
      end
      S_PRD, S_PCHK: addr = {page, last};
      default: ;
    endcase
  end
endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq
  import pps_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128,
  parameter int QUIET_CYC  = 15000,
  parameter int POLL_LIMIT = 600000
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start_i,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_i,
  input  logic [$clog2(PAGE_BYTES)-1:0]     count_m1_i,
  output logic [$clog2(PAGE_BYTES)-1:0]     buf_addr_o,
  input  logic [DATA_W-1:0]                 buf_data_i,
  output logic [ADDR_W-1:0]                 mem_addr_o,
  output logic [DATA_W-1:0]                 mem_wdata_o,
  output logic                              mem_we_o,
  output logic                              mem_re_o,
  input  logic [DATA_W-1:0]                 mem_rdata_i,
  output logic                              busy_o,
  output logic                              done_o,
  output logic                              timeout_o
);
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int TMAX   = (QUIET_CYC > POLL_LIMIT) ? QUIET_CYC : POLL_LIMIT;
  localparam int TW     = $clog2(TMAX + 1);
  localparam int TGL_BIT = 6;

  pps_state_t        st_q, st_d;
  logic [OFS_W-1:0]  idx_q, idx_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [OFS_W-1:0]  last_q, last_d;

  logic          t_load, t_dec, t_zero;
  logic [TW-1:0] t_val;
  logic          tg_clr, tg_sample, tg_settled;

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    page_d    = page_q;
    last_d    = last_q;
    t_load    = 1'b0;
    t_val     = '0;
    t_dec     = 1'b0;
    tg_clr    = 1'b0;
    tg_sample = 1'b0;
    case (st_q)
      S_IDLE: if (start_i) begin
        st_d   = S_UNLK;
        idx_d  = '0;
        page_d = page_i;
        last_d = count_m1_i;
        tg_clr = 1'b1;
      end
      S_UNLK: begin
        if (idx_q == OFS_W'(UNLOCK_LEN - 1)) begin
          st_d  = S_LOAD;
          idx_d = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      S_LOAD: begin
        if (idx_q == last_q) begin
          st_d   = S_QUIET;
          t_load = 1'b1;
          t_val  = TW'(QUIET_CYC - 1);
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      S_QUIET: begin
        if (t_zero) begin
          st_d   = S_PRD;
          t_load = 1'b1;
          t_val  = TW'(POLL_LIMIT - 1);
        end else begin
          t_dec = 1'b1;
        end
      end
      S_PRD: begin
        t_dec = 1'b1;
        st_d  = S_PCHK;
      end
      S_PCHK: begin
        tg_sample = 1'b1;
        if (tg_settled)  st_d = S_FOK;
        else if (t_zero) st_d = S_FTO;
        else begin
          t_dec = 1'b1;
          st_d  = S_PRD;
        end
      end
      S_FOK, S_FTO: st_d = S_IDLE;
      default:      st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      page_q <= '0;
      last_q <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      page_q <= page_d;
      last_q <= last_d;
    end
  end

  pps_down_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .dec      (t_dec),
    .zero     (t_zero)
  );

  pps_toggle_cmp u_tgl (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tg_clr),
    .sample  (tg_sample),
    .bit_i   (mem_rdata_i[TGL_BIT]),
    .settled (tg_settled)
  );

  pps_bus_mux #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W)
  ) u_mux (
    .st       (st_q),
    .idx      (idx_q),
    .page     (page_q),
    .last     (last_q),
    .buf_data (buf_data_i),
    .addr     (mem_addr_o),
    .wdata    (mem_wdata_o)
  );

  assign buf_addr_o = idx_q;
  assign mem_we_o   = (st_q == S_UNLK) || (st_q == S_LOAD);
  assign mem_re_o   = (st_q == S_PRD);
  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = (st_q == S_FOK);
  assign timeout_o  = (st_q == S_FTO);
endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
  parameter int PAGE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              timeout_o,
  input logic [PAGE_W-1:0] page_q
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o)); // R9
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(mem_we_o || mem_re_o)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o); // R7
  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && timeout_o)); // R10
  AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || timeout_o) |=> !busy_o); // R10
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !$past(done_o || timeout_o)) |-> $stable(page_q)); // R8
endmodule

bind page_prog_seq pps_checker #(.PAGE_W(PAGE_W)) u_pps_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_we_o  (mem_we_o),
  .mem_re_o  (mem_re_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .timeout_o (timeout_o),
  .page_q    (page_q)
);

// File: tb/tb_page_prog_seq.sv
module tb_page_prog_seq;
  localparam int QC = 20;
  localparam int PL = 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [9:0] page_i = '0;
  logic [6:0] count_m1_i = '0;
  logic [6:0] buf_addr_o;
  logic [7:0] buf_data_i;
  logic [16:0] mem_addr_o;
  logic [7:0] mem_wdata_o;
  logic       mem_we_o, mem_re_o;
  logic [7:0] mem_rdata_i;
  logic       busy_o, done_o, timeout_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] seed = 8'h00;

  always #10 clk = ~clk;

  assign buf_data_i = 8'(buf_addr_o * 3) ^ seed;

  page_prog_seq #(.QUIET_CYC(QC), .POLL_LIMIT(PL)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .page_i(page_i),
    .count_m1_i(count_m1_i), .buf_addr_o(buf_addr_o), .buf_data_i(buf_data_i),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
    .mem_re_o(mem_re_o), .mem_rdata_i(mem_rdata_i), .busy_o(busy_o),
    .done_o(done_o), .timeout_o(timeout_o));

  // bus monitor
  int cyc = 0;
  int wn = 0;
  int rn = 0;
  int viol9 = 0;
  logic [16:0] wl_a [0:1023];
  logic [7:0]  wl_d [0:1023];
  int          wl_t [0:1023];
  logic [16:0] rl_a [0:1023];
  int          rl_t [0:1023];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (mem_we_o) begin
        wl_a[wn % 1024] <= mem_addr_o;
        wl_d[wn % 1024] <= mem_wdata_o;
        wl_t[wn % 1024] <= cyc;
        wn <= wn + 1;
      end
      if (mem_re_o) begin
        rl_a[rn % 1024] <= mem_addr_o;
        rl_t[rn % 1024] <= cyc;
        rn <= rn + 1;
      end
      if ((mem_we_o && mem_re_o) || (!busy_o && (mem_we_o || mem_re_o)))
        viol9 <= viol9 + 1;
    end
  end

  // device model: bit 6 flips on each read until flip budget used
  int rcount = 0;
  int rbase_dev = 0;
  int flips = 0;
  logic [7:0] rd_q = 8'h00;
  assign mem_rdata_i = rd_q;
  always @(posedge clk) begin
    if (mem_re_o) begin
      int k;
      k = rcount - rbase_dev;
      rd_q <= {1'b1, (k <= flips) ? k[0] : flips[0], 6'h15};
      rcount <= rcount + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start(input logic [9:0] pg, input logic [6:0] cm1);
    @(negedge clk);
    page_i = pg; count_m1_i = cm1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
  endtask

  task automatic wait_end(output bit got_done, output bit got_to);
    int n = 0;
    while (!done_o && !timeout_o && n < 5000) begin
      @(negedge clk); n++;
    end
    got_done = done_o; got_to = timeout_o;
    @(negedge clk);
    chk(!done_o && !timeout_o, "R6 single-cycle pulse", done_o, 0);
    chk(!busy_o, "R10 busy low after end", busy_o, 0);
  endtask

  task automatic t_reset();
    chk(!busy_o && !done_o && !timeout_o, "R1 status at reset", {busy_o, done_o, timeout_o}, 0);
    chk(!mem_we_o && !mem_re_o, "R1 strobes at reset", {mem_we_o, mem_re_o}, 0);
  endtask

  task automatic t_program(input logic [9:0] pg, input logic [6:0] cm1,
                           input int fl, input logic [7:0] sd);
    int wb, rb, nw, bad;
    bit gd, gt;
    seed = sd; flips = fl; rbase_dev = rcount;
    wb = wn; rb = rn;
    do_start(pg, cm1);
    wait_end(gd, gt);
    @(negedge clk);
    nw = wn - wb;
    chk(gd && !gt, "R6 done reported", {gd, gt}, 2);
    chk(nw == 3 + cm1 + 1, "R3 write count", nw, 3 + cm1 + 1);
    chk(wl_a[wb % 1024] == 17'h5555 && wl_d[wb % 1024] == 8'hAA, "R2 unlock 1",
        wl_d[wb % 1024], 8'hAA);
    chk(wl_a[(wb + 1) % 1024] == 17'h2AAA && wl_d[(wb + 1) % 1024] == 8'h55, "R2 unlock 2",
        wl_d[(wb + 1) % 1024], 8'h55);
    chk(wl_a[(wb + 2) % 1024] == 17'h5555 && wl_d[(wb + 2) % 1024] == 8'hA0, "R2 unlock 3",
        wl_d[(wb + 2) % 1024], 8'hA0);
    bad = 0;
    for (int k = 0; k <= int'(cm1); k++) begin
      int j;
      j = (wb + 3 + k) % 1024;
      if (wl_a[j] != {pg, 7'(k)} || wl_d[j] != (8'(k * 3) ^ sd)) bad++;
    end
    chk(bad == 0, "R3 data stream", bad, 0);
    bad = 0;
    for (int k = 1; k < nw; k++)
      if (wl_t[(wb + k) % 1024] != wl_t[wb % 1024] + k) bad++;
    chk(bad == 0, "R3 back-to-back writes", bad, 0);
    chk(rl_t[rb % 1024] - wl_t[(wb + nw - 1) % 1024] - 1 >= QC, "R4 quiet gap",
        rl_t[rb % 1024] - wl_t[(wb + nw - 1) % 1024] - 1, QC);
    chk(rn - rb == fl + 2, "R6 poll read count", rn - rb, fl + 2);
    chk(rl_a[rb % 1024] == {pg, cm1}, "R5 poll address", rl_a[rb % 1024], {pg, cm1});
    chk(rl_t[(rb + 1) % 1024] - rl_t[rb % 1024] == 2, "R5 poll spacing",
        rl_t[(rb + 1) % 1024] - rl_t[rb % 1024], 2);
  endtask

  task automatic t_timeout();
    int rb, r_end;
    bit gd, gt;
    flips = 1000000; rbase_dev = rcount; rb = rn;
    do_start(10'h155, 7'd3);
    wait_end(gd, gt);
    chk(gt && !gd, "R7 timeout reported", {gd, gt}, 1);
    r_end = rn;
    chk(r_end - rb >= PL / 2 - 2 && r_end - rb <= PL / 2 + 2, "R7 poll length",
        r_end - rb, PL / 2);
    repeat (20) @(negedge clk);
    chk(rn == r_end, "R7 polling stopped", rn, r_end);
  endtask

  task automatic t_ignore();
    int wb, bad, w_end;
    bit gd, gt;
    flips = 2; rbase_dev = rcount; seed = 8'h3C; wb = wn;
    do_start(10'h0A5, 7'd9);
    repeat (4) @(negedge clk);
    page_i = 10'h3FF; count_m1_i = 7'd100; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_end(gd, gt);
    @(negedge clk);
    chk(wn - wb == 13, "R8 write count kept", wn - wb, 13);
    bad = 0;
    for (int k = 0; k < 10; k++)
      if (wl_a[(wb + 3 + k) % 1024][16:7] != 10'h0A5) bad++;
    chk(bad == 0, "R8 page kept", bad, 0);
    w_end = wn;
    repeat (40) @(negedge clk);
    chk(wn == w_end && !busy_o, "R8 no second operation", wn - w_end, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_program(10'h001, 7'd0, 0, 8'h5A);
    t_program(10'h2C3, 7'd127, 5, 8'hC1);
    t_program(10'h3FF, 7'd17, 1, 8'h00);
    t_ignore();
    t_timeout();
    chk(viol9 == 0, "R9 strobe rules", viol9, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule